// File: doc/BRIEF.md
# Adaptive Per-PC Load Prediction Mode Selector

This block chooses, for a load that is about to miss, how the core should handle it. There are three choices: leave the load alone, predict its value inside the current context, or hand the predicted value to a freshly spawned speculative thread. The choice is made per load PC. A small direct-mapped table keeps statistics for each outcome class: the forward progress the core made under that class, and how many cycles that took.

When a prediction window closes, a resolve event reports the PC, the class that was used, the instructions issued and the cycles elapsed. These are added to the matching counters. When a query arrives, the block estimates each class's average progress with no divider: the progress sum is shifted right by the floor of log2 of the cycle sum. A predicting class may be used only if its estimate is strictly above the estimate for the no-prediction class. The most aggressive permitted class wins. If no spare hardware context exists, a threaded choice falls back to in-context prediction.

Top module: `load_mode_selector`

## Requirements
- R1: A query (`query_vld_i` high) produces `sel_vld_o` high on the next cycle, with `sel_mode_o` coded 0 = no prediction, 1 = in-context prediction, 2 = threaded prediction. Code 3 is never produced. With no query, `sel_vld_o` is low on the next cycle and `sel_mode_o` holds its last value.
- R2: Statistics are kept per table entry, selected by PC bits [IDX_LO+IDX_W-1:IDX_LO] (bits [5:2] by default). PCs that differ only outside these bits share one entry, and PCs that differ inside them do not interfere.
- R3: A class's average is its progress sum shifted right by floor(log2(cycle sum)). A class whose cycle sum is zero counts as unmeasured, and its average is the raw progress sum.
- R4: The no-prediction class is always permitted. Class 1 or class 2 is permitted when it is unmeasured, or when its average is strictly greater than the no-prediction average. Equal averages do not permit it.
- R5: Among the permitted classes, threaded is chosen over in-context, and in-context over none.
- R6: When threaded is permitted but `ctx_free_i` is low, the output is 1. This holds even if in-context prediction is not itself permitted.
- R7: A resolve and a query in the same cycle are handled as if the resolve came first: the query sees the updated sums.
- R8: A resolve adds its instruction count and cycle count to the sums of its class. If either addition overflows its field (PROG_W or CYC_W bits), both full-precision sums of that class are halved (shifted right by one) before they are stored.
- R9: A resolve carrying class code 3 changes no statistics.
- R10: Reset clears every sum to zero, drives `sel_vld_o` low and drives `sel_mode_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| query_vld_i | input | 1 | Mode query for `query_pc_i` |
| query_pc_i | input | PC_W | PC of the load being queried |
| ctx_free_i | input | 1 | A hardware context is free for spawning |
| res_vld_i | input | 1 | Resolve event valid |
| res_pc_i | input | PC_W | PC of the resolved load |
| res_cls_i | input | 2 | Class used (0 none, 1 in-context, 2 threaded) |
| res_insn_i | input | PROG_W | Instructions issued during the window |
| res_cyc_i | input | CYC_W | Cycles elapsed during the window |
| sel_vld_o | output | 1 | Mode result valid |
| sel_mode_o | output | 2 | Chosen mode |

## Verification
The assertions assume that `query_vld_i`, `ctx_free_i` and the resolve fields are stable and known at each rising edge. They also assume that reset is applied before any query. The assertions then check how `sel_vld_o` follows a query, that a busy-context query never returns the threaded code, that the reserved code never appears, and that the mode holds between queries.

The stimulus changes inputs only one time unit after a rising edge. It includes class code 3 on a resolve only to check that such a resolve is dropped. Its sums are sized so that exactly one case crosses the progress overflow boundary. Each expected mode is worked out from the sums shifted by floor(log2) of the cycle sum.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

    localparam int unsigned N_CLASS = 3;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_THREAD = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    // floor(log2(v)); zero maps to zero
    function automatic logic [4:0] flog2_32(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/lsel_avg.sv
module lsel_avg #(
    parameter int unsigned PROG_W = 16,
    parameter int unsigned CYC_W  = 16
) (
    input  logic [PROG_W-1:0] prog_i,
    input  logic [CYC_W-1:0]  cyc_i,
    output logic [PROG_W-1:0] avg_o
);
    import lsel_pkg::*;

    logic [31:0] cyc_ext;
    logic [4:0]  shamt;

    always_comb begin
        cyc_ext = 32'(cyc_i);
        shamt   = flog2_32(cyc_ext);
        avg_o   = prog_i >> shamt;
    end
endmodule

// File: rtl/lsel_accum.sv
module lsel_accum #(
    parameter int unsigned PROG_W = 16,
    parameter int unsigned CYC_W  = 16
) (
    input  logic [PROG_W-1:0] prog_i,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic [PROG_W-1:0] add_prog_i,
    input  logic [CYC_W-1:0]  add_cyc_i,
    output logic [PROG_W-1:0] prog_o,
    output logic [CYC_W-1:0]  cyc_o
);
    logic [PROG_W:0] psum;
    logic [CYC_W:0]  csum;
    logic            ovf;

    always_comb begin
        psum = {1'b0, prog_i} + {1'b0, add_prog_i};
        csum = {1'b0, cyc_i} + {1'b0, add_cyc_i};
        ovf  = psum[PROG_W] | csum[CYC_W];
        // R8: halve both sums of the class when either would overflow
        prog_o = ovf ? psum[PROG_W:1] : psum[PROG_W-1:0];
        cyc_o  = ovf ? csum[CYC_W:1]  : csum[CYC_W-1:0];
    end
endmodule

// File: rtl/lsel_decide.sv
module lsel_decide #(
    parameter int unsigned PROG_W = 16,
    parameter int unsigned CYC_W  = 16
) (
    input  logic [PROG_W-1:0] prog_i [lsel_pkg::N_CLASS],
    input  logic [CYC_W-1:0]  cyc_i  [lsel_pkg::N_CLASS],
    input  logic              ctx_free_i,
    output logic [1:0]        mode_o
);
    import lsel_pkg::*;

    logic [PROG_W-1:0] avg [N_CLASS];
    logic [N_CLASS-1:1] permit;

    for (genvar k = 0; k < N_CLASS; k++) begin : g_avg
        lsel_avg #(.PROG_W(PROG_W), .CYC_W(CYC_W)) avg_i (
            .prog_i (prog_i[k]),
            .cyc_i  (cyc_i[k]),
            .avg_o  (avg[k])
        );
    end

    for (genvar k = 1; k < N_CLASS; k++) begin : g_permit
        // R4: unmeasured classes, or a strictly better average
        assign permit[k] = (cyc_i[k] == '0) || (avg[k] > avg[0]);
    end

    always_comb begin
        // R5 priority, R6 fallback without a free context
        if (permit[2])      mode_o = ctx_free_i ? MODE_THREAD : MODE_SINGLE;
        else if (permit[1]) mode_o = MODE_SINGLE;
        else                mode_o = MODE_NONE;
    end
endmodule

// File: rtl/load_mode_selector.sv
module load_mode_selector #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned IDX_LO = 2,
    parameter int unsigned PROG_W = 16,
    parameter int unsigned CYC_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              query_vld_i,
    input  logic [PC_W-1:0]   query_pc_i,
    input  logic              ctx_free_i,
    input  logic              res_vld_i,
    input  logic [PC_W-1:0]   res_pc_i,
    input  logic [1:0]        res_cls_i,
    input  logic [PROG_W-1:0] res_insn_i,
    input  logic [CYC_W-1:0]  res_cyc_i,
    output logic              sel_vld_o,
    output logic [1:0]        sel_mode_o
);
    import lsel_pkg::*;

    localparam int unsigned ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][N_CLASS-1:0][PROG_W-1:0] prog;
        logic [ENTRIES-1:0][N_CLASS-1:0][CYC_W-1:0]  cyc;
        logic                                        vld;
        logic [1:0]                                  mode;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]  res_idx, q_idx;
    logic              res_ok;
    logic [PROG_W-1:0] old_prog, acc_prog;
    logic [CYC_W-1:0]  old_cyc, acc_cyc;
    logic [PROG_W-1:0] q_prog [N_CLASS];
    logic [CYC_W-1:0]  q_cyc  [N_CLASS];
    logic [1:0]        dec_mode;
    logic              unused_pc_bits;

    assign res_idx        = res_pc_i[IDX_LO +: IDX_W];
    assign q_idx          = query_pc_i[IDX_LO +: IDX_W];
    // R9: class code 3 is dropped
    assign res_ok         = res_vld_i && (res_cls_i != MODE_RSVD);
    assign unused_pc_bits = ^{query_pc_i, res_pc_i};

    // Select the sums being updated
    always_comb begin
        old_prog = '0;
        old_cyc  = '0;
        for (int k = 0; k < N_CLASS; k++) begin
            if (res_cls_i == 2'(k)) begin
                old_prog = st_q.prog[res_idx][k];
                old_cyc  = st_q.cyc[res_idx][k];
            end
        end
    end

    lsel_accum #(.PROG_W(PROG_W), .CYC_W(CYC_W)) accum_i (
        .prog_i     (old_prog),
        .cyc_i      (old_cyc),
        .add_prog_i (res_insn_i),
        .add_cyc_i  (res_cyc_i),
        .prog_o     (acc_prog),
        .cyc_o      (acc_cyc)
    );

    // R7: query sees the same-cycle resolve
    always_comb begin
        for (int k = 0; k < N_CLASS; k++) begin
            if (res_ok && (res_idx == q_idx) && (res_cls_i == 2'(k))) begin
                q_prog[k] = acc_prog;
                q_cyc[k]  = acc_cyc;
            end else begin
                q_prog[k] = st_q.prog[q_idx][k];
                q_cyc[k]  = st_q.cyc[q_idx][k];
            end
        end
    end

    lsel_decide #(.PROG_W(PROG_W), .CYC_W(CYC_W)) decide_i (
        .prog_i     (q_prog),
        .cyc_i      (q_cyc),
        .ctx_free_i (ctx_free_i),
        .mode_o     (dec_mode)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = query_vld_i;
        if (query_vld_i) st_d.mode = dec_mode;
        if (res_ok) begin
            for (int k = 0; k < N_CLASS; k++) begin
                if (res_cls_i == 2'(k)) begin
                    st_d.prog[res_idx][k] = acc_prog;
                    st_d.cyc[res_idx][k]  = acc_cyc;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_vld_o  = st_q.vld;
    assign sel_mode_o = st_q.mode;
endmodule

// File: rtl/lsel_chk.sv
module lsel_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       query_vld_i,
    input logic       ctx_free_i,
    input logic       sel_vld_o,
    input logic [1:0] sel_mode_o
);
    // R1
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        query_vld_i |=> sel_vld_o);

    // R1
    vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !query_vld_i |=> !sel_vld_o);

    // R1
    mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_vld_o |-> (sel_mode_o != 2'd3));

    // R1
    mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!query_vld_i && rst_ni) |=> $stable(sel_mode_o));

    // R6
    busy_fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (query_vld_i && !ctx_free_i) |=> (sel_mode_o != 2'd2));
endmodule

bind load_mode_selector lsel_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .query_vld_i (query_vld_i),
    .ctx_free_i  (ctx_free_i),
    .sel_vld_o   (sel_vld_o),
    .sel_mode_o  (sel_mode_o)
);

// File: tb/load_mode_selector_tb_top.sv
`timescale 1ns/1ps
module load_mode_selector_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        query_vld_i;
    logic [31:0] query_pc_i;
    logic        ctx_free_i;
    logic        res_vld_i;
    logic [31:0] res_pc_i;
    logic [1:0]  res_cls_i;
    logic [15:0] res_insn_i;
    logic [15:0] res_cyc_i;
    logic        sel_vld_o;
    logic [1:0]  sel_mode_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk_i = ~clk_i;   // 250 MHz

    load_mode_selector dut_i (
        .clk_i, .rst_ni, .query_vld_i, .query_pc_i, .ctx_free_i,
        .res_vld_i, .res_pc_i, .res_cls_i, .res_insn_i, .res_cyc_i,
        .sel_vld_o, .sel_mode_o
    );

    typedef struct packed {
        logic        rv;
        logic [31:0] rpc;
        logic [1:0]  rcls;
        logic [15:0] rins;
        logic [15:0] rcyc;
        logic        qv;
        logic [31:0] qpc;
        logic        free;
        logic [1:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // R4 R5: entry 0 unmeasured, free -> threaded
        '{1'b0, 32'h0,   2'd0, 16'd0,     16'd0,  1'b1, 32'h100, 1'b1, 2'd2, 4'd4},
        // R6: busy -> in-context
        '{1'b0, 32'h0,   2'd0, 16'd0,     16'd0,  1'b1, 32'h100, 1'b0, 2'd1, 4'd6},
        // R2: baseline avg 64>>4 = 4
        '{1'b1, 32'h100, 2'd0, 16'd64,    16'd16, 1'b1, 32'h100, 1'b1, 2'd2, 4'd2},
        // R7: threaded avg 2 lands same cycle -> in-context
        '{1'b1, 32'h100, 2'd2, 16'd32,    16'd16, 1'b1, 32'h100, 1'b1, 2'd1, 4'd7},
        // R4: in-context avg 40>>3 = 5 > 4
        '{1'b1, 32'h100, 2'd1, 16'd40,    16'd8,  1'b1, 32'h100, 1'b1, 2'd1, 4'd4},
        // R3: in-context 40>>4 = 2 -> none
        '{1'b1, 32'h100, 2'd1, 16'd0,     16'd8,  1'b1, 32'h100, 1'b1, 2'd0, 4'd3},
        // R5: threaded 232>>5 = 7 -> threaded
        '{1'b1, 32'h100, 2'd2, 16'd200,   16'd16, 1'b1, 32'h100, 1'b1, 2'd2, 4'd5},
        // R6: busy, in-context not permitted, still 1
        '{1'b0, 32'h0,   2'd0, 16'd0,     16'd0,  1'b1, 32'h100, 1'b0, 2'd1, 4'd6},
        // R2: other entry unaffected
        '{1'b0, 32'h0,   2'd0, 16'd0,     16'd0,  1'b1, 32'h104, 1'b1, 2'd2, 4'd2},
        // R9: class 3 resolve ignored
        '{1'b1, 32'h100, 2'd3, 16'd0,     16'd1000, 1'b1, 32'h100, 1'b1, 2'd2, 4'd9},
        // R1: no query -> vld low, mode held
        '{1'b1, 32'h108, 2'd0, 16'd48,    16'd16, 1'b0, 32'h0,   1'b1, 2'd2, 4'd1},
        '{1'b1, 32'h108, 2'd1, 16'd24,    16'd8,  1'b0, 32'h0,   1'b1, 2'd2, 4'd1},
        // R4 R2: equal avg (3 vs 3) not permitted; alias 0x148
        '{1'b1, 32'h108, 2'd2, 16'd8,     16'd8,  1'b1, 32'h148, 1'b1, 2'd0, 4'd4},
        '{1'b1, 32'h10C, 2'd0, 16'h4000,  16'd16, 1'b0, 32'h0,   1'b1, 2'd0, 4'd1},
        '{1'b1, 32'h10C, 2'd2, 16'd0,     16'd16, 1'b0, 32'h0,   1'b1, 2'd0, 4'd1},
        '{1'b1, 32'h10C, 2'd1, 16'hF000,  16'd4,  1'b0, 32'h0,   1'b1, 2'd0, 4'd1},
        // R8: overflow halves -> 0x8800>>2 > 0x400 -> in-context
        '{1'b1, 32'h10C, 2'd1, 16'h2000,  16'd4,  1'b1, 32'h10C, 1'b1, 2'd1, 4'd8},
        // R1: idle cycle holds mode
        '{1'b0, 32'h0,   2'd0, 16'd0,     16'd0,  1'b0, 32'h0,   1'b1, 2'd1, 4'd1}
    };

    task automatic check(input logic ok, input int req, input int act, input int exp,
                         input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        res_vld_i   = 1'b0;
        res_pc_i    = '0;
        res_cls_i   = '0;
        res_insn_i  = '0;
        res_cyc_i   = '0;
        query_vld_i = 1'b0;
        query_pc_i  = '0;
        ctx_free_i  = 1'b1;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        check(sel_vld_o == 1'b0, 10, int'(sel_vld_o), 0, "vld after reset");
        check(sel_mode_o == 2'd0, 10, int'(sel_mode_o), 0, "mode after reset");

        for (int i = 0; i < NV; i++) begin
            res_vld_i   = VEC[i].rv;
            res_pc_i    = VEC[i].rpc;
            res_cls_i   = VEC[i].rcls;
            res_insn_i  = VEC[i].rins;
            res_cyc_i   = VEC[i].rcyc;
            query_vld_i = VEC[i].qv;
            query_pc_i  = VEC[i].qpc;
            ctx_free_i  = VEC[i].free;
            @(posedge clk_i);
            #1;
            check(sel_vld_o == VEC[i].qv, 1, int'(sel_vld_o), int'(VEC[i].qv), "valid");
            check(sel_mode_o == VEC[i].exp, int'(VEC[i].req), int'(sel_mode_o),
                  int'(VEC[i].exp), $sformatf("mode vec %0d", i));
        end
        idle_inputs();

        // R10: reset clears entry 2 (which gave 0) -> unmeasured -> threaded
        do_reset();
        check(sel_mode_o == 2'd0, 10, int'(sel_mode_o), 0, "mode after 2nd reset");
        query_vld_i = 1'b1;
        query_pc_i  = 32'h108;
        ctx_free_i  = 1'b1;
        @(posedge clk_i);
        #1;
        check(sel_mode_o == 2'd2, 10, int'(sel_mode_o), 2, "table cleared");
        idle_inputs();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule